// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 28-bit in-segment effective address into a real address by searching a hashed page table held in ordinary memory. The caller supplies the segment register value that covers the address. The caller also supplies the access kind (load, store or instruction fetch) and whether the access comes from user mode. The walker hashes the segment ID with the page index. It then reads the table one 32-bit word per memory handshake, first in the primary group and then in the secondary group, and compares each entry against a tag built from the same inputs.

On a hit it checks the page protection for the access kind and sets the entry's history bits in memory when they change. It returns the real address and the granted permissions. Any failure returns a fault code. A page that has not yet been stored to is handed back without write permission, so that the first store walks the table again and sets the changed bit. The table base and group mask are inputs. One walk runs at a time, and each walk ends with a single response.

Top module: `hpt_walker`

## Requirements
- R1: The primary group address is `tbl_base_i + (((vsid ^ pidx) << 6) & tbl_mask_i)`, where vsid is segment bits 23:0 and pidx is effective address bits 27:12 (zero-extended). Entry i of a group starts at group + 8*i: word 0 holds the match fields and word 1 sits at +4.
- R2: An entry matches when word0 bit 31 (valid) is 1, word0 bit 6 equals the pass (0 for primary, 1 for secondary), bits 30:7 equal vsid, and bits 5:0 equal pidx[15:10]. The secondary group uses the bitwise complement of the 32-bit hash and is searched only after all 8 primary entries miss.
- R3: Entries in a group are read in ascending order. The first matching entry ends the search, and its word 1 is read next.
- R4: If both groups miss, the response faults with code 0x42000000 for a store and 0x40000000 for a load or a fetch, after exactly 16 word reads.
- R5: A fetch (kind 2) whose segment bit 24 (no-execute) is set faults with code 0x10000000 and makes no memory access.
- R6: The key is segment bit 25 in user mode and bit 26 otherwise. The protection field pp is word1 bits 1:0. With key 0, pp 0 to 2 grant read and write, and pp 3 grants read only. With key 1, pp 0 grants nothing, pp 1 and 3 grant read only, and pp 2 grants read and write. Execute is granted when segment bit 24 is clear.
- R7: A load (kind 0, or the reserved kind 3) needs read, a store (kind 1) needs write, and a fetch needs execute. A missing permission faults with 0x0A000000 for a store and 0x08000000 otherwise, and nothing is written to memory.
- R8: On a permitted hit, word1 bit 8 (referenced) is set, and bit 7 (changed) is set for a store. Word 1 is written back only when this changes its value.
- R9: A permitted non-store hit reports write permission as 0 even when the page allows writes.
- R10: The response address is word1 bits 31:12 followed by effective address bits 11:0. The permissions are reported as {execute, write, read}.
- R11: The memory request, address, write enable and write data hold steady until the cycle in which `mem_ack_i` is high.
- R12: Each accepted request produces exactly one `rsp_valid_o` pulse of one cycle, and `req_ready_o` is high only while no walk is in progress (including after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken when ready) |
| req_ready_o | output | 1 | Walker idle |
| req_ea_i | input | 28 | Effective address within the segment |
| req_seg_i | input | 27 | Segment value: {key_super, key_user, no_exec, vsid[23:0]} |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_user_i | input | 1 | User-mode access |
| tbl_base_i | input | 32 | Table base address |
| tbl_mask_i | input | 32 | Group offset mask |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_code_o | output | 32 | Fault code, 0 on success |
| rsp_addr_o | output | 32 | Real address |
| rsp_perm_o | output | 3 | {execute, write, read} |

## Verification
The hardest case to reach is a hit in the secondary group that lies behind entries that almost match. In the bench, the primary group holds the same tag with the secondary flag set, plus an invalid copy with the flag clear. The secondary group holds a flag-clear copy ahead of the real entry. The bench sets up these tables by writing its memory model directly, and counts the word reads to confirm that all 8 primary entries and the right number of secondary entries were visited. The memory responder adds a varying delay before each ack, which covers the rule that the request must hold steady while it waits.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W = 32;
  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;
  localparam int API_W  = 6;
  localparam int POFS_W = 12;
  localparam int EA_W   = 28;
  localparam int SEG_W  = 27;

  localparam int SEG_KS = 26;
  localparam int SEG_KU = 25;
  localparam int SEG_NX = 24;

  localparam int PTE_V   = 31;
  localparam int PTE_H   = 6;
  localparam int PTE_REF = 8;
  localparam int PTE_CHG = 7;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  localparam logic [WORD_W-1:0] CODE_NX      = 32'h1000_0000;
  localparam logic [WORD_W-1:0] CODE_MISS_LD = 32'h4000_0000;
  localparam logic [WORD_W-1:0] CODE_MISS_ST = 32'h4200_0000;
  localparam logic [WORD_W-1:0] CODE_PROT_LD = 32'h0800_0000;
  localparam logic [WORD_W-1:0] CODE_PROT_ST = 32'h0A00_0000;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GROUP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [PIDX_W-1:0] pidx_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] grp_addr_o,
  output logic [WORD_W-1:0] tag_o
);
  logic [ADDR_W-1:0] hash, hsel, goff;

  always_comb begin
    hash       = ADDR_W'(vsid_i ^ VSID_W'(pidx_i));
    hsel       = sec_i ? ~hash : hash;
    goff       = (hsel << GROUP_SHIFT) & mask_i;
    grp_addr_o = base_i + goff;
    tag_o      = {1'b0, vsid_i, 1'b0, pidx_i[PIDX_W-1 -: API_W]};
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] tag_i,
  input  logic              sec_i,
  output logic              hit_o
);
  logic [WORD_W-1:0] cmp;

  always_comb begin
    cmp        = w0_i;
    cmp[PTE_V] = 1'b0;
    cmp[PTE_H] = 1'b0;
    hit_o      = w0_i[PTE_V] && (w0_i[PTE_H] == sec_i) && (cmp == tag_i);
  end
endmodule

// File: rtl/hpt_prot.sv
module hpt_prot
  import hpt_pkg::*;
(
  input  logic       key_i,
  input  logic [1:0] pp_i,
  input  logic       nx_i,
  input  acc_e       kind_i,
  output perm_t      perm_o,
  output logic       grant_o
);
  always_comb begin
    perm_o.x = ~nx_i;
    if (!key_i) begin
      perm_o.r = 1'b1;
      perm_o.w = (pp_i != 2'd3);
    end else begin
      perm_o.r = (pp_i != 2'd0);
      perm_o.w = (pp_i == 2'd2);
    end
    unique case (kind_i)
      ACC_STORE: grant_o = perm_o.w;
      ACC_FETCH: grant_o = perm_o.x;
      default:   grant_o = perm_o.r;
    endcase
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [EA_W-1:0]   req_ea_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_user_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [ADDR_W-1:0] tbl_mask_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [WORD_W-1:0] rsp_code_o,
  output logic [WORD_W-1:0] rsp_addr_o,
  output logic [2:0]        rsp_perm_o
);
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int ENTRY_BYTES = 2 * WORD_BYTES;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
  localparam int IDX_W       = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GROUP_ENTRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_WB, S_RSP} state_e;

  state_e            state_q;
  logic [EA_W-1:0]   ea_q;
  logic [VSID_W-1:0] vsid_q;
  logic              nx_q, key_q, sec_q;
  acc_e              kind_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] wdata_q;
  logic              rsp_fault_q;
  logic [WORD_W-1:0] rsp_code_q, rsp_addr_q;
  perm_t             rsp_perm_q;

  logic [ADDR_W-1:0] grp_addr, entry_addr;
  logic [WORD_W-1:0] tag, w1_upd;
  logic              ent_hit, grant;
  perm_t             perm_raw, perm_final;
  acc_e              req_kind;

  assign req_kind = acc_e'(req_kind_i);

  hpt_hash #(.ADDR_W(ADDR_W), .GROUP_SHIFT(GROUP_SHIFT)) u_hash (
    .vsid_i     (vsid_q),
    .pidx_i     (ea_q[EA_W-1:POFS_W]),
    .sec_i      (sec_q),
    .base_i     (tbl_base_i),
    .mask_i     (tbl_mask_i),
    .grp_addr_o (grp_addr),
    .tag_o      (tag)
  );

  hpt_match u_match (
    .w0_i  (mem_rdata_i),
    .tag_i (tag),
    .sec_i (sec_q),
    .hit_o (ent_hit)
  );

  hpt_prot u_prot (
    .key_i   (key_q),
    .pp_i    (mem_rdata_i[1:0]),
    .nx_i    (nx_q),
    .kind_i  (kind_q),
    .perm_o  (perm_raw),
    .grant_o (grant)
  );

  always_comb begin
    entry_addr = grp_addr + (ADDR_W'(idx_q) << ENTRY_SHIFT);
    w1_upd = mem_rdata_i;
    w1_upd[PTE_REF] = 1'b1;
    if (kind_q == ACC_STORE) w1_upd[PTE_CHG] = 1'b1;
    perm_final = perm_raw;
    if (kind_q != ACC_STORE) perm_final.w = 1'b0;
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_RD0) || (state_q == S_RD1) || (state_q == S_WB);
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = (state_q == S_RD0) ? entry_addr : entry_addr + ADDR_W'(WORD_BYTES);
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = (state_q == S_RSP);
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign rsp_perm_o  = rsp_perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      ea_q        <= '0;
      vsid_q      <= '0;
      nx_q        <= 1'b0;
      key_q       <= 1'b0;
      sec_q       <= 1'b0;
      kind_q      <= ACC_LOAD;
      idx_q       <= '0;
      wdata_q     <= '0;
      rsp_fault_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_addr_q  <= '0;
      rsp_perm_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          ea_q   <= req_ea_i;
          vsid_q <= req_seg_i[VSID_W-1:0];
          nx_q   <= req_seg_i[SEG_NX];
          key_q  <= req_user_i ? req_seg_i[SEG_KU] : req_seg_i[SEG_KS];
          kind_q <= req_kind;
          sec_q  <= 1'b0;
          idx_q  <= '0;
          if (req_kind == ACC_FETCH && req_seg_i[SEG_NX]) begin
            rsp_fault_q <= 1'b1;
            rsp_code_q  <= CODE_NX;
            rsp_addr_q  <= '0;
            rsp_perm_q  <= '0;
            state_q     <= S_RSP;
          end else begin
            state_q <= S_RD0;
          end
        end
        S_RD0: if (mem_ack_i) begin
          if (ent_hit) begin
            state_q <= S_RD1;
          end else if (idx_q == IDX_LAST) begin
            idx_q <= '0;
            if (!sec_q) begin
              sec_q <= 1'b1;
            end else begin
              rsp_fault_q <= 1'b1;
              rsp_code_q  <= (kind_q == ACC_STORE) ? CODE_MISS_ST : CODE_MISS_LD;
              rsp_addr_q  <= '0;
              rsp_perm_q  <= '0;
              state_q     <= S_RSP;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_RD1: if (mem_ack_i) begin
          if (!grant) begin
            rsp_fault_q <= 1'b1;
            rsp_code_q  <= (kind_q == ACC_STORE) ? CODE_PROT_ST : CODE_PROT_LD;
            rsp_addr_q  <= '0;
            rsp_perm_q  <= '0;
            state_q     <= S_RSP;
          end else begin
            rsp_fault_q <= 1'b0;
            rsp_code_q  <= '0;
            rsp_addr_q  <= {mem_rdata_i[WORD_W-1:POFS_W], ea_q[POFS_W-1:0]};
            rsp_perm_q  <= perm_final;
            wdata_q     <= w1_upd;
            // history bits already present: skip the write cycle
            state_q     <= (w1_upd != mem_rdata_i) ? S_WB : S_RSP;
          end
        end
        S_WB:  if (mem_ack_i) state_q <= S_RSP;
        S_RSP: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r11_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_no_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && kind_q != ACC_STORE |-> !rsp_perm_o[1]);

  a_r8_ref_in_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[PTE_REF]);

  a_r5_nx_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && kind_q == ACC_FETCH && nx_q |-> rsp_fault_o && rsp_code_o == CODE_NX);

  a_r7_fault_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o == (rsp_code_o != '0));
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
  import hpt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'h0000_3FC0;
  localparam int MEM_WORDS = 4096;

  typedef struct {
    logic        fault;
    logic [31:0] code;
    logic [31:0] addr;
    logic [2:0]  perm;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_user = 1'b0;
  logic [27:0] req_ea = '0;
  logic [26:0] req_seg = '0;
  logic [1:0] req_kind = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic rsp_valid, rsp_fault;
  logic [31:0] rsp_code, rsp_addr;
  logic [2:0] rsp_perm;

  logic [31:0] mem [MEM_WORDS];
  exp_t  exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0, hold_bad = 0;
  int lat = 0;
  logic pend = 1'b0, finished = 1'b0;
  logic [31:0] pend_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ea_i(req_ea), .req_seg_i(req_seg), .req_kind_i(req_kind), .req_user_i(req_user),
    .tbl_base_i(BASE), .tbl_mask_i(MASK),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_code_o(rsp_code),
    .rsp_addr_o(rsp_addr), .rsp_perm_o(rsp_perm)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic int wi(logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  function automatic logic [31:0] grp(logic [23:0] vsid, logic [15:0] pidx, logic sec);
    logic [31:0] h;
    h = {8'h00, vsid ^ {8'h00, pidx}};
    if (sec) h = ~h;
    return BASE + ((h << 6) & MASK);
  endfunction

  task automatic put(logic [23:0] vsid, logic [27:0] ea, logic gsec, int slot, logic v,
                     logic hflag, logic [19:0] rpn, logic [1:0] pp, logic r, logic c);
    int k;
    k = wi(grp(vsid, ea[27:12], gsec) + 32'(8 * slot));
    mem[k]     = {v, vsid, hflag, ea[27:22]};
    mem[k + 1] = {rpn, 3'b000, r, c, 5'b00000, pp};
  endtask

  // Reference walk built from the requirement text
  task automatic model(logic [27:0] ea, logic [26:0] seg, logic [1:0] kind, logic user,
                       output exp_t e, output int nrd, output int nwr,
                       output int widx, output logic [31:0] wval);
    logic found, key, rd, wr, ok;
    logic [31:0] w0, w1, nw;
    logic [15:0] pidx;
    pidx = ea[27:12];
    e = '{fault: 1'b0, code: 32'h0, addr: 32'h0, perm: 3'b000};
    nrd = 0; nwr = 0; widx = -1; wval = '0; found = 1'b0;
    if (kind == 2'd2 && seg[24]) begin
      e.fault = 1'b1; e.code = 32'h1000_0000; return;
    end
    for (int p = 0; p < 2 && !found; p++) begin
      for (int i = 0; i < 8 && !found; i++) begin
        int k;
        k = wi(grp(seg[23:0], pidx, p[0]) + 32'(8 * i));
        w0 = mem[k];
        nrd++;
        if (w0[31] && w0[6] == p[0] && w0[30:7] == seg[23:0] && w0[5:0] == pidx[15:10]) begin
          found = 1'b1; widx = k + 1;
        end
      end
    end
    if (!found) begin
      e.fault = 1'b1;
      e.code = (kind == 2'd1) ? 32'h4200_0000 : 32'h4000_0000;
      return;
    end
    nrd++;
    w1 = mem[widx];
    wval = w1;
    key = user ? seg[25] : seg[26];
    case ({key, w1[1:0]})
      3'b000, 3'b001, 3'b010: begin rd = 1; wr = 1; end
      3'b011:                 begin rd = 1; wr = 0; end
      3'b100:                 begin rd = 0; wr = 0; end
      3'b110:                 begin rd = 1; wr = 1; end
      default:                begin rd = 1; wr = 0; end
    endcase
    ok = (kind == 2'd1) ? wr : (kind == 2'd2) ? !seg[24] : rd;
    if (!ok) begin
      e.fault = 1'b1;
      e.code = (kind == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000;
      return;
    end
    nw = w1 | 32'h100 | ((kind == 2'd1) ? 32'h80 : 32'h0);
    if (nw != w1) nwr = 1;
    wval = nw;
    e.addr = {w1[31:12], ea[11:0]};
    e.perm = {!seg[24], (kind == 2'd1) ? wr : 1'b0, rd};
  endtask

  // Memory responder with a rotating latency
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; pend = 1'b0; lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; pend = 1'b0;
    end else if (mem_req) begin
      if (pend && (mem_addr !== pend_addr)) hold_bad++;
      if (lat == 0) begin
        int k;
        k = wi(mem_addr);
        mem_ack = 1'b1; pend = 1'b0;
        if (k < 0 || k >= MEM_WORDS) begin
          mem_rdata = '0; rd_cnt++;
        end else if (mem_we) begin
          mem[k] = mem_wdata; wr_cnt++;
        end else begin
          mem_rdata = mem[k]; rd_cnt++;
        end
        lat = (rd_cnt + wr_cnt) % 3;
      end else begin
        lat--; pend = 1'b1; pend_addr = mem_addr;
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_cnt++;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "fault", 32'(rsp_fault), 32'(e.fault));
        chk(t, "code", rsp_code, e.code);
        if (!e.fault) begin
          chk("R10", "addr", rsp_addr, e.addr);
          chk(t, "perm", 32'(rsp_perm), 32'(e.perm));
        end
      end
    end
  end

  task automatic run(logic [27:0] ea, logic [26:0] seg, logic [1:0] kind, logic user, string tag);
    exp_t e;
    int nrd, nwr, widx, rd0, wr0, r0, h0;
    logic [31:0] wval;
    model(ea, seg, kind, user, e, nrd, nwr, widx, wval);
    rd0 = rd_cnt; wr0 = wr_cnt; r0 = rsp_cnt; h0 = hold_bad;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ea = ea; req_seg = seg; req_kind = kind; req_user = user; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "ready while busy", 32'(req_ready), 32'(0));
    while (rsp_cnt == r0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(tag, "word reads", 32'(rd_cnt - rd0), 32'(nrd));
    chk("R8", "writes", 32'(wr_cnt - wr0), 32'(nwr));
    if (widx >= 0) chk("R8", "word1 in memory", mem[widx], wval);
    chk("R11", "request held", 32'(hold_bad - h0), 32'(0));
    chk("R12", "one response", 32'(rsp_cnt - r0), 32'(1));
  endtask

  function automatic logic [26:0] mkseg(logic ks, logic ku, logic nx, logic [23:0] vsid);
    return {ks, ku, nx, vsid};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R12", "reset ready", 32'(req_ready), 32'(1));
    chk("R12", "reset rsp_valid", 32'(rsp_valid), 32'(0));
    chk("R11", "reset mem_req", 32'(mem_req), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // A: primary hit, slot 3
    put(24'h000011, 28'h1402345, 1'b0, 3, 1'b1, 1'b0, 20'hABCDE, 2'd2, 1'b0, 1'b0);
    run(28'h1402345, mkseg(0, 0, 0, 24'h000011), 2'd0, 1'b0, "R1");
    run(28'h1402345, mkseg(0, 0, 0, 24'h000011), 2'd0, 1'b0, "R9");
    run(28'h1402345, mkseg(0, 0, 0, 24'h000011), 2'd1, 1'b0, "R8");
    run(28'h1402345, mkseg(0, 0, 0, 24'h000011), 2'd1, 1'b0, "R8");
    run(28'h1402345, mkseg(0, 0, 1, 24'h000011), 2'd2, 1'b0, "R5");
    run(28'h1402345, mkseg(0, 0, 1, 24'h000011), 2'd0, 1'b0, "R6");

    // B: secondary hit behind near-matches
    put(24'h000020, 28'h0005ABC, 1'b0, 0, 1'b1, 1'b1, 20'h11111, 2'd2, 1'b0, 1'b0);
    put(24'h000020, 28'h0005ABC, 1'b0, 1, 1'b0, 1'b0, 20'h22222, 2'd2, 1'b0, 1'b0);
    put(24'h000020, 28'h0005ABC, 1'b1, 2, 1'b1, 1'b0, 20'h33333, 2'd2, 1'b0, 1'b0);
    put(24'h000020, 28'h0005ABC, 1'b1, 5, 1'b1, 1'b1, 20'h44444, 2'd2, 1'b0, 1'b0);
    run(28'h0005ABC, mkseg(0, 0, 0, 24'h000020), 2'd2, 1'b0, "R2");

    // C: two matches, first wins; user key 1
    put(24'h000040, 28'h0C07010, 1'b0, 1, 1'b1, 1'b0, 20'h55555, 2'd1, 1'b0, 1'b0);
    put(24'h000040, 28'h0C07010, 1'b0, 4, 1'b1, 1'b0, 20'h66666, 2'd2, 1'b0, 1'b0);
    run(28'h0C07010, mkseg(0, 1, 0, 24'h000040), 2'd1, 1'b1, "R7");
    run(28'h0C07010, mkseg(0, 1, 0, 24'h000040), 2'd0, 1'b1, "R3");

    // D: pp 0 under key 1 and key 0
    put(24'h000060, 28'h0009FFF, 1'b0, 7, 1'b1, 1'b0, 20'h77777, 2'd0, 1'b0, 1'b0);
    run(28'h0009FFF, mkseg(0, 1, 0, 24'h000060), 2'd0, 1'b1, "R7");
    run(28'h0009FFF, mkseg(0, 1, 0, 24'h000060), 2'd2, 1'b1, "R6");
    run(28'h0009FFF, mkseg(1, 1, 0, 24'h000060), 2'd1, 1'b0, "R7");
    run(28'h0009FFF, mkseg(0, 1, 0, 24'h000060), 2'd1, 1'b0, "R6");

    // E: pp 3 is read only under key 0
    put(24'h000070, 28'h000B123, 1'b0, 0, 1'b1, 1'b0, 20'h88888, 2'd3, 1'b1, 1'b0);
    run(28'h000B123, mkseg(0, 0, 0, 24'h000070), 2'd1, 1'b0, "R7");
    run(28'h000B123, mkseg(0, 0, 0, 24'h000070), 2'd3, 1'b0, "R6");

    // F: full miss for each kind
    run(28'h0000777, mkseg(0, 0, 0, 24'h000001), 2'd0, 1'b0, "R4");
    run(28'h0000777, mkseg(0, 0, 0, 24'h000001), 2'd1, 1'b0, "R4");
    run(28'h0000777, mkseg(0, 0, 0, 24'h000001), 2'd2, 1'b0, "R4");

    chk("R12", "scoreboard drained", 32'(exp_q.size()), 32'(0));
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule